// File: doc/BRIEF.md
# Rotate and Extend-Rotate Unit

This block rotates a byte, word or long operand left or right, in one of two modes. In plain mode the operand bits circulate among themselves. In extend mode a one-bit extend flag joins the operand as an extra top bit, so the bits circulate in a ring one bit wider than the operand. Along with the sized result, the unit returns the updated extend flag and four condition bits: zero, negative, carry and overflow.

The count is 6 bits wide. In plain mode it is reduced by masking to the operand width. In extend mode it is reduced modulo the ring length, which is 9, 17 or 33. The inputs are sampled on every rising clock edge, and the results appear on registered outputs one cycle later. There is no handshake. Instruction decoding and writeback are the caller's job.

Top module: `rot_unit`

## Requirements
- R1: Encodings: `size_sel` 00 selects a byte, 01 a word, and 10 or 11 a long. `dir_left` is 1 for a left rotate and 0 for a right rotate. `ext_mode` is 0 for plain mode and 1 for extend mode. In plain mode the result is the sized operand rotated by the count modulo the width (8, 16 or 32).
- R2: In plain mode with a nonzero count, carry is result bit 0 after a left rotate and the result MSB after a right rotate. This holds even when the count is a multiple of the width and the result therefore equals the operand. A zero count clears carry.
- R3: In plain mode the extend output equals the extend input.
- R4: In extend mode the count is reduced modulo width+1. The {extend, operand} ring is rotated by that amount, and the extend bit enters at the end that was vacated.
- R5: In extend mode the new extend bit is the last operand bit moved out: bit (count-1) after a right rotate and bit (width-count) after a left rotate. When the reduced count equals the width, the old extend bit lands at the far end of the result.
- R6: In extend mode carry equals the new extend bit. When the reduced count is zero, the result equals the operand, the extend bit is unchanged, and carry copies it.
- R7: Zero is set exactly when the sized result is all zeros.
- R8: Negative equals the most significant bit of the sized result.
- R9: Overflow is always 0.
- R10: For byte and word sizes, operand bits above the size have no effect, and result bits above the size are 0.
- R11: Outputs show the operation sampled at the previous rising edge. While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_in | input | DATA_W | Operand |
| cnt_in | input | CNT_W | Rotate count, 0 to 63 |
| size_sel | input | 2 | Operand size |
| dir_left | input | 1 | 1 = left, 0 = right |
| ext_mode | input | 1 | 1 = rotate through the extend flag |
| x_in | input | 1 | Current extend flag |
| res_out | output | DATA_W | Rotated result, zero above the size |
| x_out | output | 1 | Updated extend flag |
| flag_z | output | 1 | Zero |
| flag_n | output | 1 | Negative |
| flag_c | output | 1 | Carry |
| flag_v | output | 1 | Overflow (always 0) |

## Verification
A wrong count reduction or ring splice shows up at the result and extend outputs one cycle after the operation is applied. The errors cluster at the wrap points: counts equal to the width, equal to width+1, and equal to multiples of either. Flag faults appear in the same cycle as the result. Carry and extend can disagree in extend mode, and extend can drift in plain mode; the embedded checks catch both. The bench also sweeps every count for each size, direction and mode against a bitwise ring model.

// File: rtl/rot_pkg.sv
package rot_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_LALT = 2'b11
    } rot_size_e;
endpackage

// File: rtl/rot_lane.sv
module rot_lane #(
    parameter int W     = 8,
    parameter int CNT_W = 6
) (
    input  logic [W-1:0]     op,
    input  logic [CNT_W-1:0] cnt,
    input  logic             left,
    input  logic             ext,
    input  logic             x_in,
    output logic [W-1:0]     res,
    output logic             x_new,
    output logic             c_new
);
    localparam int RING_W = W + 1;
    localparam logic [CNT_W-1:0] MASK = CNT_W'(W - 1);

    logic [CNT_W-1:0]  plain_k;
    logic [CNT_W-1:0]  ring_k;
    logic [W-1:0]      plain_r;
    logic [RING_W-1:0] ring;
    logic [RING_W-1:0] ring_r;

    always_comb begin
        plain_k = cnt & MASK;
        ring_k  = CNT_W'(32'(cnt) % RING_W);
        ring    = {x_in, op};
        if (left) begin
            plain_r = W'(({op, op} << plain_k) >> W);
            ring_r  = RING_W'(({ring, ring} << ring_k) >> RING_W);
        end else begin
            plain_r = W'({op, op} >> plain_k);
            ring_r  = RING_W'({ring, ring} >> ring_k);
        end
        if (ext) begin
            res   = ring_r[W-1:0];
            x_new = ring_r[W];
            c_new = ring_r[W];
        end else begin
            res   = plain_r;
            x_new = x_in;
            c_new = (cnt != '0) && (left ? plain_r[0] : plain_r[W-1]);
        end
    end
endmodule

// File: rtl/rot_unit.sv
module rot_unit #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [1:0]        size_sel,
    input  logic              dir_left,
    input  logic              ext_mode,
    input  logic              x_in,
    output logic [DATA_W-1:0] res_out,
    output logic              x_out,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_c,
    output logic              flag_v
);
    import rot_pkg::*;

    localparam int BW     = DATA_W / 4;
    localparam int HW     = DATA_W / 2;
    localparam int NLANES = 3;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              x;
        logic              z;
        logic              n;
        logic              c;
        logic              v;
        rot_size_e         sz;
        logic              ext;
        logic              xin;
    } rot_state_t;

    rot_state_t st_d, st_q;

    logic [DATA_W-1:0] lane_res [NLANES];
    logic              lane_x   [NLANES];
    logic              lane_c   [NLANES];

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        localparam int LW = BW << g;
        logic [LW-1:0] r_w;
        rot_lane #(.W(LW), .CNT_W(CNT_W)) u_lane (
            .op    (op_in[LW-1:0]),
            .cnt   (cnt_in),
            .left  (dir_left),
            .ext   (ext_mode),
            .x_in  (x_in),
            .res   (r_w),
            .x_new (lane_x[g]),
            .c_new (lane_c[g])
        );
        assign lane_res[g] = DATA_W'(r_w);
    end

    always_comb begin
        int sel;
        rot_size_e sz;
        sz  = rot_size_e'(size_sel);
        sel = (sz == SZ_BYTE) ? 0 : (sz == SZ_WORD) ? 1 : 2;
        st_d.res = lane_res[sel];
        st_d.x   = lane_x[sel];
        st_d.c   = lane_c[sel];
        st_d.z   = (lane_res[sel] == '0);
        case (sel)
            0:       st_d.n = lane_res[0][BW-1];
            1:       st_d.n = lane_res[1][HW-1];
            default: st_d.n = lane_res[2][DATA_W-1];
        endcase
        st_d.v   = 1'b0;
        st_d.sz  = sz;
        st_d.ext = ext_mode;
        st_d.xin = x_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_out = st_q.res;
    assign x_out   = st_q.x;
    assign flag_z  = st_q.z;
    assign flag_n  = st_q.n;
    assign flag_c  = st_q.c;
    assign flag_v  = st_q.v;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_v); // R9
    AST_EXT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ext |-> (flag_c == x_out)); // R6
    AST_PLAIN_KEEPS_X: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ext |-> (x_out == st_q.xin)); // R3
    AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sz == SZ_BYTE) |-> (res_out[DATA_W-1:BW] == '0)); // R10
    AST_WORD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sz == SZ_WORD) |-> (res_out[DATA_W-1:HW] == '0)); // R10
    AST_ZN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z |-> !flag_n); // R7
endmodule

// File: tb/tb_rot_unit.sv
`timescale 1ns/1ps
module tb_rot_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] op_in = '0;
    logic [5:0]  cnt_in = '0;
    logic [1:0]  size_sel = '0;
    logic        dir_left = 0, ext_mode = 0, x_in = 0;
    logic [31:0] res_out;
    logic        x_out, flag_z, flag_n, flag_c, flag_v;

    int tests_run = 0;
    int tests_failed = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rot_unit dut (
        .clk(clk), .rst_n(rst_n), .op_in(op_in), .cnt_in(cnt_in),
        .size_sel(size_sel), .dir_left(dir_left), .ext_mode(ext_mode),
        .x_in(x_in), .res_out(res_out), .x_out(x_out), .flag_z(flag_z),
        .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic ref_model(input logic [31:0] op, input int cnt, input logic [1:0] sz,
                             input logic left, input logic ext, input logic xi,
                             output logic [31:0] r, output logic [4:0] f);
        int w, len, k;
        logic ring [0:32];
        logic nr   [0:32];
        logic xo, c;
        w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        len = ext ? w + 1 : w;
        for (int i = 0; i < 33; i++) begin ring[i] = 1'b0; nr[i] = 1'b0; end
        for (int i = 0; i < w; i++) ring[i] = op[i];
        if (ext) ring[w] = xi;
        k = cnt % len;
        for (int i = 0; i < len; i++) begin
            if (left) nr[(i + k) % len] = ring[i];
            else      nr[i] = ring[(i + k) % len];
        end
        r = '0;
        for (int i = 0; i < w; i++) r[i] = nr[i];
        if (ext) begin
            xo = nr[w];
            c  = xo;
        end else begin
            xo = xi;
            c  = (cnt != 0) ? (left ? r[0] : r[w-1]) : 1'b0;
        end
        f = {xo, (r == 0), r[w-1], c, 1'b0};
    endtask

    task automatic check(input string req, input logic [36:0] got, input logic [36:0] exp);
        tests_run++;
        if (got !== exp) begin
            tests_failed++;
            $display("FAIL %s: got res=%h x=%b z=%b n=%b c=%b v=%b expected res=%h x=%b z=%b n=%b c=%b v=%b",
                     req, got[36:5], got[4], got[3], got[2], got[1], got[0],
                     exp[36:5], exp[4], exp[3], exp[2], exp[1], exp[0]);
        end
    endtask

    function automatic logic [36:0] outs();
        return {res_out, x_out, flag_z, flag_n, flag_c, flag_v};
    endfunction

    task automatic run_case(input string req, input logic [31:0] op, input int cnt,
                            input logic [1:0] sz, input logic left, input logic ext,
                            input logic xi);
        logic [31:0] r;
        logic [4:0]  f;
        @(negedge clk);
        op_in = op; cnt_in = 6'(cnt); size_sel = sz;
        dir_left = left; ext_mode = ext; x_in = xi;
        @(negedge clk);
        ref_model(op, cnt, sz, left, ext, xi, r, f);
        check(req, outs(), {r, f});
    endtask

    task automatic run_hard(input string req, input logic [31:0] op, input int cnt,
                            input logic [1:0] sz, input logic left, input logic ext,
                            input logic xi, input logic [36:0] exp);
        @(negedge clk);
        op_in = op; cnt_in = 6'(cnt); size_sel = sz;
        dir_left = left; ext_mode = ext; x_in = xi;
        @(negedge clk);
        check(req, outs(), exp);
    endtask

    task automatic t_reset();
        rst_n = 0;
        op_in = 32'hFFFF_FFFF; cnt_in = 6'd3; x_in = 1; ext_mode = 1;
        repeat (3) @(negedge clk);
        check("R11 reset", outs(), '0);
        rst_n = 1;
    endtask

    task automatic t_plain_known();
        // {res, x, z, n, c, v}
        run_hard("R1 R2 byte left 1", 32'h81, 1, 2'b00, 1, 0, 0, {32'h03, 5'b00010});
        run_hard("R1 R2 word right 4", 32'h8001, 4, 2'b01, 0, 0, 0, {32'h1800, 5'b00000});
        run_hard("R2 long left 32 keeps operand", 32'h8000_0001, 32, 2'b10, 1, 0, 0,
                 {32'h8000_0001, 5'b00110});
        run_hard("R2 zero count clears carry", 32'h8000_0001, 0, 2'b10, 1, 0, 0,
                 {32'h8000_0001, 5'b00100});
        run_hard("R8 long right 1 to MSB", 32'h1, 1, 2'b11, 0, 0, 0, {32'h8000_0000, 5'b00110});
    endtask

    task automatic t_plain_x();
        run_hard("R3 plain keeps x=1", 32'h5, 2, 2'b00, 1, 0, 1, {32'h14, 5'b10000});
        run_hard("R3 plain keeps x=0", 32'h5, 2, 2'b00, 1, 0, 0, {32'h14, 5'b00000});
    endtask

    task automatic t_ext_known();
        run_hard("R4 R5 R7 byte xr 1", 32'h01, 1, 2'b00, 0, 1, 0, {32'h00, 5'b11010});
        run_hard("R4 R5 byte xl 1", 32'h80, 1, 2'b00, 1, 1, 1, {32'h01, 5'b10010});
        run_hard("R5 byte xr count=width", 32'h01, 8, 2'b00, 0, 1, 1, {32'h03, 5'b00000});
        run_hard("R6 byte xr count 9", 32'h5A, 9, 2'b00, 0, 1, 1, {32'h5A, 5'b10010});
        run_hard("R6 long xl count 33", 32'h1234_5678, 33, 2'b10, 1, 1, 0, {32'h1234_5678, 5'b00000});
        run_hard("R4 long xr count 34", 32'h0000_0003, 34, 2'b10, 0, 1, 0, {32'h0000_0001, 5'b10010});
        run_hard("R4 word xl count 18", 32'h8000, 18, 2'b01, 1, 1, 0, {32'h0000, 5'b11010});
    endtask

    task automatic t_upper();
        run_hard("R10 byte upper ignored", 32'hABCD_EF00, 3, 2'b00, 1, 0, 0, {32'h0, 5'b01000});
        run_hard("R10 word upper ignored", 32'hFFFF_8000, 1, 2'b01, 1, 0, 0, {32'h1, 5'b00010});
        run_case("R10 byte ext upper", 32'hFFFF_FF7F, 5, 2'b00, 0, 1, 1);
    endtask

    task automatic t_latency();
        @(negedge clk);
        op_in = 32'h1; cnt_in = 6'd4; size_sel = 2'b10; dir_left = 1; ext_mode = 0; x_in = 0;
        @(negedge clk);
        op_in = 32'h2;
        #1;
        check("R11 one-cycle latency hold", outs(), {32'h10, 5'b00000});
        @(negedge clk);
        check("R11 one-cycle latency update", outs(), {32'h20, 5'b00000});
    endtask

    task automatic t_sweep();
        logic [31:0] ops [4] = '{32'h8000_0001, 32'hA5C3_0F96, 32'h0000_0000, 32'h7FFF_FFFE};
        for (int s = 0; s < 3; s++)
            for (int m = 0; m < 2; m++)
                for (int d = 0; d < 2; d++)
                    for (int c = 0; c < 64; c++)
                        for (int o = 0; o < 4; o++)
                            run_case(m ? "R4 R5 R6 ext sweep" : "R1 R2 plain sweep",
                                     ops[o], c, 2'(s), d[0], m[0], o[0] ^ c[0]);
    endtask

    initial begin
        t_reset();
        t_plain_known();
        t_plain_x();
        t_ext_known();
        t_upper();
        t_latency();
        t_sweep();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end
endmodule